// File: doc/BRIEF.md
# Address Contention Busy Arbiter

This block sits next to a memory with two independent access ports, called left and right. In each clock cycle it checks whether both ports are enabled and point at the same address. When they do, it lets one of them proceed and raises an active-low busy flag towards the other. It also suppresses the write strobe of the side that lost, so the array never sees two writes to one location in the same cycle. The decision uses only the enables and the addresses. Whether an access is a read or a write plays no part in it.

The side that has held its enable and address for at least one cycle counts as settled. A settled side beats one that has just arrived. When both arrive in the same cycle, the left port wins. The winner keeps its claim while both ports stay enabled on unchanged addresses. As soon as either side moves or drops its enable, the claim is released, and the next collision is judged again by order of arrival.

A mode input turns the block into a follower for width expansion. In follower mode no comparison is made and both busy outputs stay inactive. The two busy inputs, driven from another instance that arbitrates, then act purely as per-port write inhibits.

The internal states are FREE (no collision claimed), LEFT_OWNS (left won, right is busy) and RIGHT_OWNS (right won, left is busy). The state moves in these ways:
- Any state goes to FREE when there is no collision or when follower mode is selected.
- An owning state stays where it is on a hold: the collision persists and both ports are settled.
- Otherwise a collision leads to a fresh decision. The result is RIGHT_OWNS if only the right port is settled, and LEFT_OWNS in every other case, the simultaneous tie included.

Top module: `cab_busy_arbiter`

## Requirements
- R1: In arbitrating mode (`slave_mode`=0), a busy output (active low, 0 = busy) is driven low only in a cycle where both enables are 1 and `l_addr` equals `r_addr`. With no such collision, both busy outputs read 1.
- R2: In a collision where one port held the same enable and address in the previous cycle and the other did not, the port that was already there wins. The newcomer's busy output goes low in the same cycle.
- R3: When both ports arrive at a colliding address in the same cycle, the left port wins (`r_busy_n`=0). The two busy outputs are never 0 at the same time.
- R4: The write-request inputs `l_wr` and `r_wr` have no effect on the busy outputs.
- R5: A write enable `x_wr_go` (active high) equals `x_en & x_wr` unless that port is blocked. In arbitrating mode a port is blocked while its own busy output is 0. A read by the losing port is not inhibited.
- R6: A winner keeps the win while both ports remain enabled on unchanged, equal addresses. When either address changes, the collision is judged afresh by arrival order, so a winner that moves away and comes back loses to the port that stayed.
- R7: In follower mode (`slave_mode`=1), both busy outputs stay 1 and a port is blocked exactly when its busy input (`x_busy_in_n`, active low) is 0. In arbitrating mode the busy inputs have no effect.
- R8: While `rst_n` is 0, with both ports disabled, both busy outputs read 1 and no write enable is asserted. After reset no port counts as settled.
- R9: Dropping either enable releases the busy indication in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 = follower: busy inputs inhibit writes; 0 = arbitrate |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left write inhibit in follower mode, active low |
| r_busy_in_n | input | 1 | Right write inhibit in follower mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_go | output | 1 | Left array write strobe actually applied |
| r_wr_go | output | 1 | Right array write strobe actually applied |

## Verification
The bench builds the arbiter with `ADDR_W` = 4. With only sixteen addresses, a pseudo-random walk of both ports collides often. That brings newcomer-versus-settled races, simultaneous ties, holds and releases within reach in a short run, next to the directed sequences. The narrow address also makes a one-step move away and back quick to set up, which is how the loss of a held win is exercised.

// File: rtl/cab_pkg.sv
package cab_pkg;

    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } cab_state_t;

    localparam int unsigned PORTS = 2;
    localparam int unsigned PL    = 0;
    localparam int unsigned PR    = 1;

endpackage

// File: rtl/cab_arrival.sv
// Remembers last cycle's enable and address of one port so the decider
// can tell a port that was already present from one that just arrived.
module cab_arrival #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);

    logic              prev_en_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_en_q   <= en;
            prev_addr_q <= addr;
        end
    end

    always_comb begin
        settled = en && prev_en_q && (addr == prev_addr_q);
    end

endmodule

// File: rtl/cab_decider.sv
// Ownership state machine: decides which side wins a same-address collision.
module cab_decider
    import cab_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_settled,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_settled,
    output logic              l_lost,
    output logic              r_lost
);

    cab_state_t state_q;
    cab_state_t state_d;
    cab_state_t fresh;
    logic       hit;
    logic       hold;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        hit  = l_en && r_en && (l_addr == r_addr) && !slave_mode;
        hold = hit && l_settled && r_settled;

        if (!hit) begin
            fresh = ST_FREE;
        end else if (r_settled && !l_settled) begin
            fresh = ST_RIGHT_OWNS;
        end else begin
            fresh = ST_LEFT_OWNS;
        end

        unique case (state_q)
            ST_LEFT_OWNS:  state_d = hold ? ST_LEFT_OWNS  : fresh;
            ST_RIGHT_OWNS: state_d = hold ? ST_RIGHT_OWNS : fresh;
            ST_FREE:       state_d = fresh;
            default:       state_d = ST_FREE;
        endcase
    end

    // Outputs from the decision of this cycle
    always_comb begin
        l_lost = (state_d == ST_RIGHT_OWNS);
        r_lost = (state_d == ST_LEFT_OWNS);
    end

endmodule

// File: rtl/cab_wgate.sv
// Per-port busy drive and write strobe gating, selected by mode.
module cab_wgate (
    input  logic slave_mode,
    input  logic en,
    input  logic wr,
    input  logic lost,
    input  logic busy_in_n,
    output logic busy_out_n,
    output logic wr_go
);

    logic blocked;

    always_comb begin
        blocked    = slave_mode ? !busy_in_n : lost;
        busy_out_n = slave_mode ? 1'b1 : !lost;
        wr_go      = en && wr && !blocked;
    end

endmodule

// File: rtl/cab_busy_arbiter.sv
module cab_busy_arbiter
    import cab_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_go,
    output logic              r_wr_go
);

    logic              p_en      [PORTS];
    logic [ADDR_W-1:0] p_addr    [PORTS];
    logic              p_wr      [PORTS];
    logic              p_bin_n   [PORTS];
    logic              p_settled [PORTS];
    logic              p_lost    [PORTS];
    logic              p_bout_n  [PORTS];
    logic              p_go      [PORTS];

    always_comb begin
        p_en[PL]    = l_en;
        p_en[PR]    = r_en;
        p_addr[PL]  = l_addr;
        p_addr[PR]  = r_addr;
        p_wr[PL]    = l_wr;
        p_wr[PR]    = r_wr;
        p_bin_n[PL] = l_busy_in_n;
        p_bin_n[PR] = r_busy_in_n;
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        cab_arrival #(.ADDR_W(ADDR_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (p_en[g]),
            .addr    (p_addr[g]),
            .settled (p_settled[g])
        );

        cab_wgate u_gate (
            .slave_mode (slave_mode),
            .en         (p_en[g]),
            .wr         (p_wr[g]),
            .lost       (p_lost[g]),
            .busy_in_n  (p_bin_n[g]),
            .busy_out_n (p_bout_n[g]),
            .wr_go      (p_go[g])
        );
    end

    cab_decider #(.ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .l_en       (l_en),
        .l_addr     (l_addr),
        .l_settled  (p_settled[PL]),
        .r_en       (r_en),
        .r_addr     (r_addr),
        .r_settled  (p_settled[PR]),
        .l_lost     (p_lost[PL]),
        .r_lost     (p_lost[PR])
    );

    always_comb begin
        l_busy_n = p_bout_n[PL];
        r_busy_n = p_bout_n[PR];
        l_wr_go  = p_go[PL];
        r_wr_go  = p_go[PR];
    end

endmodule

// File: rtl/cab_busy_arbiter_chk.sv
module cab_busy_arbiter_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_go,
    input logic              r_wr_go
);

    logic collide;
    assign collide = l_en && r_en && (l_addr == r_addr);

    assert_busy_needs_collision_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> (collide && !slave_mode));

    assert_never_both_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    assert_loser_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && (!l_busy_n || !r_busy_n)) |->
            ((l_busy_n || !l_wr_go) && (r_busy_n || !r_wr_go)));

    assert_winner_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !slave_mode && !$past(slave_mode) && !$past(r_busy_n)
         && l_en && r_en && $past(l_en) && $past(r_en)
         && $stable(l_addr) && $stable(r_addr)) |-> !r_busy_n);

    assert_follower_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (l_busy_n && r_busy_n));

    assert_follower_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && (!l_busy_in_n || !r_busy_in_n)) |->
            ((l_busy_in_n || !l_wr_go) && (r_busy_in_n || !r_wr_go)));

endmodule

bind cab_busy_arbiter cab_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_mode  (slave_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_go     (l_wr_go),
    .r_wr_go     (r_wr_go)
);

// File: tb/cab_busy_arbiter_test.sv
`timescale 1ns/1ps
module cab_busy_arbiter_test;

    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_wr_go, r_wr_go;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cab_busy_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
    );

    typedef struct {
        logic  bl;
        logic  br;
        logic  gl;
        logic  gr;
        string req;
    } exp_t;

    exp_t exp_q[$];

    // Model state: previous inputs and current owner (0 none, 1 left, 2 right)
    logic          m_pl_en = 1'b0, m_pr_en = 1'b0;
    logic [AW-1:0] m_pl_a = '0, m_pr_a = '0;
    int            m_owner = 0;

    task automatic step(input logic sm, input logic le, input logic [AW-1:0] la, input logic lw,
                        input logic re, input logic [AW-1:0] ra, input logic rw,
                        input logic bil, input logic bir, input string req);
        exp_t e;
        logic hit, ls, rs;
        int   win;
        @(negedge clk);
        slave_mode = sm; l_en = le; l_addr = la; l_wr = lw;
        r_en = re; r_addr = ra; r_wr = rw; l_busy_in_n = bil; r_busy_in_n = bir;
        hit = le && re && (la == ra);
        ls  = le && m_pl_en && (la == m_pl_a);
        rs  = re && m_pr_en && (ra == m_pr_a);
        if (sm || !hit)                       win = 0;
        else if (m_owner != 0 && ls && rs)    win = m_owner;
        else if (rs && !ls)                   win = 2;
        else                                  win = 1;
        e.bl  = sm ? 1'b1 : (win != 2);
        e.br  = sm ? 1'b1 : (win != 1);
        e.gl  = le && lw && (sm ? bil : (win != 2));
        e.gr  = re && rw && (sm ? bir : (win != 1));
        e.req = req;
        exp_q.push_back(e);
        m_pl_en = le; m_pl_a = la; m_pr_en = re; m_pr_a = ra; m_owner = win;
    endtask

    // Monitor: compare design outputs mid-cycle against the queued items
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({l_busy_n, r_busy_n, l_wr_go, r_wr_go} !== {e.bl, e.br, e.gl, e.gr}) begin
                fails++;
                $display("FAIL %s: busy_l/busy_r/go_l/go_r got %b%b%b%b expected %b%b%b%b",
                         e.req, l_busy_n, r_busy_n, l_wr_go, r_wr_go, e.bl, e.br, e.gl, e.gr);
            end
        end
    end

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        // R8: reset state with idle ports
        repeat (2) @(negedge clk);
        #1;
        checks++;
        if ({l_busy_n, r_busy_n, l_wr_go, r_wr_go} !== 4'b1100) begin
            fails++;
            $display("FAIL R8: got %b%b%b%b expected 1100", l_busy_n, r_busy_n, l_wr_go, r_wr_go);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R1 idle");
        step(0, 1, 3, 0, 1, 5, 1, 1, 1, "R1 distinct addresses");
        step(0, 1, 3, 1, 1, 3, 1, 1, 1, "R2 newcomer right busy");
        step(0, 1, 3, 1, 1, 3, 1, 1, 1, "R6 hold left win");
        step(0, 1, 3, 0, 1, 3, 0, 1, 1, "R5 loser read not inhibited");
        step(0, 1, 3, 1, 0, 3, 1, 1, 1, "R9 release on disable");
        step(0, 1, 7, 1, 1, 7, 1, 1, 1, "R3 tie left wins");
        step(0, 1, 8, 1, 1, 7, 0, 1, 1, "R6 winner moves away");
        step(0, 1, 7, 1, 1, 7, 1, 1, 1, "R6 returner loses");
        step(0, 1, 7, 0, 1, 7, 0, 1, 1, "R4 write flags do not move win");
        step(0, 1, 7, 1, 1, 7, 1, 0, 0, "R7 busy inputs ignored in master");
        step(0, 0, 7, 1, 1, 7, 1, 1, 1, "R9 left drops");
        step(0, 1, 2, 1, 0, 2, 0, 1, 1, "R2 setup left");
        step(0, 1, 2, 0, 1, 2, 0, 1, 1, "R4 read-only collision busy");
        step(1, 1, 2, 1, 1, 2, 1, 0, 1, "R7 follower left inhibited");
        step(1, 1, 2, 1, 1, 2, 1, 1, 0, "R7 follower right inhibited");
        step(1, 1, 9, 1, 1, 9, 1, 1, 1, "R7 follower free writes");
        step(0, 1, 9, 1, 1, 9, 1, 1, 1, "R6 re-judged after mode change");

        lfsr = 8'hA5;
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] la, ra;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            la = (lfsr[0]) ? lfsr[3:2] : l_addr;
            ra = (lfsr[1]) ? lfsr[5:4] : r_addr;
            step(0, lfsr[6] | lfsr[2], la, lfsr[7], lfsr[5] | lfsr[1], ra, lfsr[3],
                 lfsr[4], lfsr[0], "R1 R2 R3 walk");
        end

        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 final idle");
        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule